// File: doc/BRIEF.md
# Link Alarm Status Interrupt Aggregator

This block gathers the alarm sources of an optical line module into a single status word and drives one interrupt line from it. Eight general-purpose alarm lines, a receive alarm vector and a transmit alarm vector are each OR-reduced into one status bit. Three link-health conditions are combined by AND. Any change of that combined value is latched until software reads the status word.

Raw threshold flags from the digital monitoring logic reach the receive and transmit alarm bits only where a writable enable mask allows them. There is one mask for the transmit side and one for the receive side. Software reaches the three registers through a simple strobed read/write port, of the kind a management-bus slave would drive. The read data is combinational on the address.

Top module: `link_alarm_hub`

## Requirements
- R1: Status bit 3 is 1 exactly when at least one of the eight `gpio_alarm` lines is 1.
- R2: Status bit 2 is the OR of every bit of `rx_alarm_vec` together with the receive monitoring flag. That flag is the OR of `mon_rx_raw & rx_enable`.
- R3: Status bit 1 is the OR of every bit of `tx_alarm_vec` together with the transmit monitoring flag. That flag is the OR of `mon_tx_raw & tx_enable`.
- R4: The transmit enable register is at address 1. Its writable bits are 7 (temperature high), 6 (temperature low), 3 (bias current high), 2 (bias current low), 1 (output power high) and 0 (output power low). A raw transmit flag on bit n reaches status bit 1 only when enable bit n is 1.
- R5: The receive enable register is at address 2. Its writable bits are 7 (receive power high) and 6 (receive power low). A raw receive flag on bit n reaches status bit 2 only when enable bit n is 1.
- R6: Status bit 0 (address 0) is set one clock after the AND of `pmd_sig_ok`, `pcs_aligned` and `phyxs_aligned` changes, in either direction. It then stays set until the status word is read.
- R7: A read strobe to address 0 clears status bit 0 at that clock edge. If the link condition changes in the same cycle as the read, the bit stays set.
- R8: When reset is released, the link condition is taken as the reference value. No change event is raised at start-up, whatever the condition is.
- R9: Status bits 15:4 read 0. Enable bits outside the writable bits of R4 and R5 read 0 after any write. A write to address 0 changes nothing, and address 3 reads 0.
- R10: `irq` is 1 exactly when any of status bits 3:0 is 1.
- R11: After reset, the status word and both enable registers read 0 and `irq` is 0, provided the alarm inputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_alarm | input | 8 | General-purpose alarm lines |
| rx_alarm_vec | input | RX_W | Receive alarm status vector |
| tx_alarm_vec | input | TX_W | Transmit alarm status vector |
| pmd_sig_ok | input | 1 | Medium signal present |
| pcs_aligned | input | 1 | Coding-layer lane alignment achieved |
| phyxs_aligned | input | 1 | Host-side lane alignment achieved |
| mon_tx_raw | input | 8 | Raw transmit monitoring threshold flags, same bit positions as the transmit enable register |
| mon_rx_raw | input | 8 | Raw receive monitoring threshold flags, same bit positions as the receive enable register |
| reg_addr | input | 2 | Register address: 0 status, 1 transmit enable, 2 receive enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 0 clears the link bit |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt, 1 while any alarm bit is set |

## Verification
Each general-purpose line and each alarm vector is driven one bit at a time and then all at zero. This shows that the OR reductions see every input and that each lands on its own status bit. The monitoring flags are driven with all raw bits set while enables are off. Single enable bits are then paired with their own raw bit, and reserved positions are driven alone. This separates correct gating from leakage and from wrong bit positions. The link condition is dropped and restored through different inputs, and is changed in the same cycle as a read, to tell latch-on-either-edge, hold, clear-on-read and read/change priority apart. Reset is released with the condition both low and high to expose a spurious start-up event.

// File: rtl/link_alarm_hub.sv
module link_alarm_hub #(
  parameter int RX_W = 16,
  parameter int TX_W = 16,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      gpio_alarm,
  input  logic [RX_W-1:0] rx_alarm_vec,
  input  logic [TX_W-1:0] tx_alarm_vec,
  input  logic            pmd_sig_ok,
  input  logic            pcs_aligned,
  input  logic            phyxs_aligned,
  input  logic [7:0]      mon_tx_raw,
  input  logic [7:0]      mon_rx_raw,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq
);

  localparam logic [7:0] TX_EN_BITS = 8'hCF;
  localparam logic [7:0] RX_EN_BITS = 8'hC0;
  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_TXEN   = 2'd1;
  localparam logic [1:0] A_RXEN   = 2'd2;

  logic [7:0] tx_en, rx_en;
  logic       link_now, link_prev, link_arm, link_evt;
  logic       ls_alarm;
  logic       tx_flag, rx_flag;
  logic       gpio_any, rx_any, tx_any;
  logic       rd_status;
  logic [3:0] alarm_bits;
  logic       unused_wbits;

  assign unused_wbits = ^reg_wdata[DW-1:8];

  assign tx_flag  = |(mon_tx_raw & tx_en);
  assign rx_flag  = |(mon_rx_raw & rx_en);
  assign gpio_any = |gpio_alarm;
  assign rx_any   = (|rx_alarm_vec) | rx_flag;
  assign tx_any   = (|tx_alarm_vec) | tx_flag;

  assign link_now  = pmd_sig_ok & pcs_aligned & phyxs_aligned;
  assign link_evt  = link_arm & (link_now != link_prev);
  assign rd_status = reg_rd & (reg_addr == A_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en <= '0;
      rx_en <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_TXEN) tx_en <= reg_wdata[7:0] & TX_EN_BITS;
      if (reg_addr == A_RXEN) rx_en <= reg_wdata[7:0] & RX_EN_BITS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_arm  <= 1'b0;
      link_prev <= 1'b0;
      ls_alarm  <= 1'b0;
    end else begin
      link_arm  <= 1'b1;
      link_prev <= link_now;
      if (link_evt)       ls_alarm <= 1'b1;
      else if (rd_status) ls_alarm <= 1'b0;
    end
  end

  assign alarm_bits = {gpio_any, rx_any, tx_any, ls_alarm};
  assign irq = |alarm_bits;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS: reg_rdata[3:0] = alarm_bits;
      A_TXEN:   reg_rdata[7:0] = tx_en;
      A_RXEN:   reg_rdata[7:0] = rx_en;
      default:  reg_rdata = '0;
    endcase
  end

  // R6
  ls_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> ls_alarm);

  // R6
  ls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_alarm && !rd_status) |=> ls_alarm);

  // R7
  ls_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !link_evt) |=> !ls_alarm);

  // R8
  no_start_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_arm) |=> !ls_alarm);

  // R10
  irq_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_alarm |-> irq);

  // R9
  en_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_en & ~TX_EN_BITS) == 8'h00) && ((rx_en & ~RX_EN_BITS) == 8'h00));

endmodule

// File: tb/link_alarm_hub_test.sv
`timescale 1ns/1ps
module link_alarm_hub_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  gpio_alarm;
  logic [15:0] rx_alarm_vec, tx_alarm_vec;
  logic        pmd_sig_ok, pcs_aligned, phyxs_aligned;
  logic [7:0]  mon_tx_raw, mon_rx_raw;
  logic [1:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_alarm_hub uut (
    .clk(clk), .rst_n(rst_n), .gpio_alarm(gpio_alarm),
    .rx_alarm_vec(rx_alarm_vec), .tx_alarm_vec(tx_alarm_vec),
    .pmd_sig_ok(pmd_sig_ok), .pcs_aligned(pcs_aligned), .phyxs_aligned(phyxs_aligned),
    .mon_tx_raw(mon_tx_raw), .mon_rx_raw(mon_rx_raw),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic link_lvl);
    @(negedge clk);
    rst_n = 1'b0;
    gpio_alarm = '0; rx_alarm_vec = '0; tx_alarm_vec = '0;
    pmd_sig_ok = link_lvl; pcs_aligned = link_lvl; phyxs_aligned = link_lvl;
    mon_tx_raw = '0; mon_rx_raw = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    do_reset(1'b0);
    cyc(2);
    peek(2'd0, d); check("R11", "status after reset", d, 16'h0000);
    peek(2'd1, d); check("R11", "tx enable after reset", d, 16'h0000);
    peek(2'd2, d); check("R11", "rx enable after reset", d, 16'h0000);
    check("R11", "irq after reset", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_startup;
    logic [15:0] d;
    do_reset(1'b1);
    cyc(4);
    peek(2'd0, d); check("R8", "no event at release with link up", d, 16'h0000);
    check("R8", "irq quiet at release", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_gpio;
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); gpio_alarm = 8'h01 << i;
      peek(2'd0, d); check("R1", $sformatf("gpio line %0d", i), d, 16'h0008);
      check("R10", "irq on gpio", {15'd0, irq}, 16'h0001);
    end
    @(negedge clk); gpio_alarm = '0;
    peek(2'd0, d); check("R1", "gpio all clear", d, 16'h0000);
    check("R10", "irq clear", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_vectors;
    logic [15:0] d;
    for (int i = 0; i < 16; i += 5) begin
      @(negedge clk); rx_alarm_vec = 16'h0001 << i;
      peek(2'd0, d); check("R2", $sformatf("rx vec bit %0d", i), d, 16'h0004);
      rx_alarm_vec = '0; tx_alarm_vec = 16'h0001 << i;
      peek(2'd0, d); check("R3", $sformatf("tx vec bit %0d", i), d, 16'h0002);
      tx_alarm_vec = '0;
    end
    @(negedge clk); rx_alarm_vec = 16'h8000; tx_alarm_vec = 16'h8000; gpio_alarm = 8'h80;
    peek(2'd0, d); check("R9", "upper status bits zero", d, 16'h000E);
    rx_alarm_vec = '0; tx_alarm_vec = '0; gpio_alarm = '0;
  endtask

  task automatic t_tx_mask;
    logic [15:0] d;
    logic [7:0] bits [6] = '{8'h80, 8'h40, 8'h08, 8'h04, 8'h02, 8'h01};
    wr(2'd1, 16'h0000);
    @(negedge clk); mon_tx_raw = 8'hFF;
    peek(2'd0, d); check("R4", "raw tx flags masked off", d, 16'h0000);
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, {8'h00, bits[i]});
      mon_tx_raw = bits[i];
      peek(2'd0, d); check("R4", $sformatf("tx enable %h own flag", bits[i]), d, 16'h0002);
      mon_tx_raw = ~bits[i];
      peek(2'd0, d); check("R4", $sformatf("tx enable %h other flags", bits[i]), d, 16'h0000);
    end
    wr(2'd1, 16'hFFFF);
    peek(2'd1, d); check("R9", "tx enable reserved bits", d, 16'h00CF);
    mon_tx_raw = 8'h30;
    peek(2'd0, d); check("R9", "tx reserved flags ignored", d, 16'h0000);
    mon_tx_raw = '0;
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_rx_mask;
    logic [15:0] d;
    wr(2'd2, 16'h0000);
    @(negedge clk); mon_rx_raw = 8'hFF;
    peek(2'd0, d); check("R5", "raw rx flags masked off", d, 16'h0000);
    wr(2'd2, 16'h0080); mon_rx_raw = 8'h80;
    peek(2'd0, d); check("R5", "rx power high enabled", d, 16'h0004);
    mon_rx_raw = 8'h40;
    peek(2'd0, d); check("R5", "rx power low not enabled", d, 16'h0000);
    wr(2'd2, 16'h0040);
    peek(2'd0, d); check("R5", "rx power low enabled", d, 16'h0004);
    wr(2'd2, 16'hFFFF);
    peek(2'd2, d); check("R9", "rx enable reserved bits", d, 16'h00C0);
    mon_rx_raw = 8'h3F;
    peek(2'd0, d); check("R9", "rx reserved flags ignored", d, 16'h0000);
    mon_rx_raw = '0;
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_link;
    logic [15:0] d;
    do_reset(1'b1);
    cyc(3);
    pcs_aligned = 1'b0;
    cyc(1);
    check("R6", "link drop latched", {15'd0, irq}, 16'h0001);
    cyc(4);
    check("R6", "link bit holds", {15'd0, irq}, 16'h0001);
    rd(2'd0, d); check("R6", "status shows link bit", d, 16'h0001);
    check("R7", "read clears link bit", {15'd0, irq}, 16'h0000);
    cyc(2);
    check("R7", "stays clear with no change", {15'd0, irq}, 16'h0000);
    phyxs_aligned = 1'b0;
    cyc(2);
    check("R6", "no event while AND stays low", {15'd0, irq}, 16'h0000);
    pcs_aligned = 1'b1; phyxs_aligned = 1'b1;
    cyc(1);
    check("R6", "link rise latched", {15'd0, irq}, 16'h0001);
    rd(2'd0, d);
    check("R7", "cleared after rise", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_read_collide;
    logic [15:0] d;
    @(negedge clk);
    reg_addr = 2'd0; reg_rd = 1'b1; pmd_sig_ok = 1'b0;
    @(negedge clk);
    reg_rd = 1'b0;
    check("R7", "change during read kept", {15'd0, irq}, 16'h0001);
    rd(2'd0, d); check("R7", "kept bit visible", d, 16'h0001);
    check("R7", "later read clears", {15'd0, irq}, 16'h0000);
    pmd_sig_ok = 1'b1;
    cyc(1);
    rd(2'd0, d);
  endtask

  task automatic t_status_write;
    logic [15:0] d;
    wr(2'd0, 16'hFFFF);
    peek(2'd0, d); check("R9", "status write ignored", d, 16'h0000);
    peek(2'd1, d); check("R9", "status write leaves tx enable", d, 16'h0000);
    peek(2'd3, d); check("R9", "unused address reads zero", d, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_startup();
    t_gpio();
    t_vectors();
    t_tx_mask();
    t_rx_mask();
    t_link();
    t_read_collide();
    t_status_write();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule